// File: doc/BRIEF.md
# Set Recency Stack with Selectable Fill Placement

This block holds the replacement state of one cache set with `WAYS` ways as an ordered recency stack: slot 0 holds the most recently used way and slot `WAYS-1` holds the least recently used way, which is always the victim for the next fill. A hit moves the hit way to the top of the stack. A fill takes the current victim way and places it at one of two depths, chosen by a placement mode.

There are three modes. Classic placement puts the filled way at the top. Bottom placement leaves the filled way at the bottom, so a way that is never touched again is the next to be evicted. Only a later hit lifts it. Bimodal placement puts the filled way at the top only when an internal pseudo-random draw succeeds, about one fill in 2^`EPS_BITS`. Otherwise it stays at the bottom. Under a thrashing access pattern, the ways already near the top keep their places.

The set's tags and data live elsewhere. The logic that chooses the mode also lives outside the block and drives `ins_mode`.

Top module: `lru_ins_stack`

## Requirements
- R1: After reset, slot i of the recency order holds way i (way 0 at the top, way `WAYS-1` at the bottom). The draw generator is loaded with `LFSR_SEED`.
- R2: `victim_way` always equals the way in the bottom slot, and the order is always a permutation of all ways. `recency_flat[i*IW +: IW]` is slot i.
- R3: A hit (`acc_valid`=1, `acc_hit`=1) on the way in slot p moves that way to slot 0. Slots 0..p-1 each move down one place, and slots below p are unchanged.
- R4: A hit on the way already in slot 0 leaves the order unchanged.
- R5: A fill (`fill_req`=1, no hit in the same cycle) with `ins_mode`=2'b00 moves the victim to slot 0 and shifts every other way down one place. The encoding 2'b11 behaves the same way.
- R6: A fill with `ins_mode`=2'b01 leaves the whole order unchanged, so the filled way remains the victim. Only a hit moves it out of the bottom slot.
- R7: A fill with `ins_mode`=2'b10 places the victim at slot 0 (as in R5) when the low `EPS_BITS` bits of a 16-bit shift register are all zero, and leaves the order unchanged otherwise. The register shifts left with new bit0 = b15^b13^b12^b10, starts at `LFSR_SEED`, and steps once per such fill, after its value has been used.
- R8: When a hit and a fill request arrive in the same cycle, only the hit is applied, and the draw generator does not step.
- R9: A cycle with neither a hit nor a fill request leaves the order unchanged. This includes `acc_valid`=1 with `acc_hit`=0.
- R10: The default `EPS_BITS` is 5, which gives a top-placement probability of 1/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A lookup to this set happens this cycle |
| acc_hit | input | 1 | The lookup hit |
| hit_way | input | IW | Way that hit |
| fill_req | input | 1 | Fill the victim way this cycle |
| ins_mode | input | 2 | Placement mode for fills |
| victim_way | output | IW | Way to replace on the next fill |
| recency_flat | output | WAYS*IW | Recency order, slot 0 in the low bits |

## Verification
The hardest case to reach from the ports is a successful bimodal draw, because it happens on only about one fill in 32. The bench builds the block with a seed whose low five bits are zero, so the first bimodal fill must go to the top. It then runs a long sequence of bimodal fills. A bit-exact model of the shift register predicts each placement, and the bench checks that at least one more top placement follows. Bottom placement is confirmed by filling the bottom slot repeatedly and then hitting that way to lift it.

// File: rtl/lis_pkg.sv
package lis_pkg;
   typedef enum logic [1:0] {
      PLACE_TOP    = 2'b00,
      PLACE_BOTTOM = 2'b01,
      PLACE_BIMOD  = 2'b10,
      PLACE_SPARE  = 2'b11
   } place_mode_e;

   localparam int DRAW_W = 16;
endpackage

// File: rtl/lis_lfsr.sv
module lis_lfsr
   import lis_pkg::*;
#(
   parameter logic [DRAW_W-1:0] SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [DRAW_W-1:0] state
);
   if (SEED == '0) begin : g_bad_seed
      $error("lis_lfsr: SEED must be nonzero");
   end

   logic fb;
   assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {state[DRAW_W-2:0], fb};
   end

   p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
endmodule

// File: rtl/lis_stack_next.sv
module lis_stack_next #(
   parameter int WAYS = 8,
   localparam int IW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0][IW-1:0] cur,
   input  logic                    en,
   input  logic [IW-1:0]           pway,
   output logic [WAYS-1:0][IW-1:0] nxt
);
   logic [IW-1:0] pos;

   always_comb begin
      pos = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (cur[i] == pway) pos = IW'(i);
      end
   end

   always_comb begin
      nxt = cur;
      if (en) begin
         nxt[0] = pway;
         for (int i = 1; i < WAYS; i++) begin
            if (i <= int'(pos)) nxt[i] = cur[i-1];
         end
      end
   end
endmodule

// File: rtl/lru_ins_stack.sv
module lru_ins_stack
   import lis_pkg::*;
#(
   parameter int              WAYS      = 8,
   parameter int              EPS_BITS  = 5,
   parameter logic [15:0]     LFSR_SEED = 16'hACE1,
   localparam int             IW        = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic                 acc_hit,
   input  logic [IW-1:0]        hit_way,
   input  logic                 fill_req,
   input  logic [1:0]           ins_mode,
   output logic [IW-1:0]        victim_way,
   output logic [WAYS*IW-1:0]   recency_flat
);
   if (WAYS < 2) begin : g_bad_ways
      $error("lru_ins_stack: WAYS must be at least 2");
   end
   if (EPS_BITS < 1 || EPS_BITS > DRAW_W - 1) begin : g_bad_eps
      $error("lru_ins_stack: EPS_BITS out of range");
   end

   logic [WAYS-1:0][IW-1:0] order, order_nxt;
   logic [DRAW_W-1:0]       draw_state;
   logic                    hit_do, fill_do, bimod_fill, draw_top;
   logic                    lift_en;
   logic [IW-1:0]           lift_way;
   place_mode_e             mode;

   assign mode       = place_mode_e'(ins_mode);
   assign hit_do     = acc_valid & acc_hit;
   assign fill_do    = fill_req & ~hit_do;
   assign bimod_fill = fill_do & (mode == PLACE_BIMOD);
   assign draw_top   = (draw_state[EPS_BITS-1:0] == '0);

   lis_lfsr #(.SEED(LFSR_SEED)) u_draw (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (bimod_fill),
      .state (draw_state)
   );

   always_comb begin
      lift_en  = 1'b0;
      lift_way = order[WAYS-1];
      if (hit_do) begin
         lift_en  = 1'b1;
         lift_way = hit_way;
      end else if (fill_do) begin
         unique case (mode)
            PLACE_BOTTOM: lift_en = 1'b0;
            PLACE_BIMOD:  lift_en = draw_top;
            default:      lift_en = 1'b1;
         endcase
      end
   end

   lis_stack_next #(.WAYS(WAYS)) u_next (
      .cur  (order),
      .en   (lift_en),
      .pway (lift_way),
      .nxt  (order_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) order[i] <= IW'(i);
      end else begin
         order <= order_nxt;
      end
   end

   assign victim_way   = order[WAYS-1];
   assign recency_flat = order;

   // Each way occupies exactly one slot (R2)
   for (genvar w = 0; w < WAYS; w++) begin : g_perm
      logic [WAYS-1:0] seen;
      always_comb begin
         for (int i = 0; i < WAYS; i++) seen[i] = (order[i] == IW'(w));
      end
      p_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(seen));
   end

   p_hit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_do |-> (int'(hit_way) < WAYS));
   p_hit_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_do |=> (order[0] == $past(hit_way)));
   p_hit_keep_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_do && hit_way != victim_way) |=> $stable(victim_way));
   p_top_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_do && (mode == PLACE_TOP || mode == PLACE_SPARE))
      |=> (order[0] == $past(victim_way)));
   p_bottom_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_do && mode == PLACE_BOTTOM) |=> $stable(order));
   p_bimod_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_do && mode == PLACE_BIMOD)
      |=> ($stable(order) || order[0] == $past(victim_way)));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_do && !fill_req) |=> $stable(order));
endmodule

// File: tb/lru_ins_stack_bench.sv
`timescale 1ns/1ps
module lru_ins_stack_bench;
   localparam int          WAYS = 8;
   localparam int          IW   = 3;
   localparam logic [15:0] SEED = 16'h1E00;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0, acc_hit = 1'b0, fill_req = 1'b0;
   logic [IW-1:0]     hit_way = '0;
   logic [1:0]        ins_mode = 2'b00;
   logic [IW-1:0]     victim_way;
   logic [WAYS*IW-1:0] recency_flat;

   int checks = 0, failures = 0, top_draws = 0;
   bit done = 1'b0;
   int mo[WAYS];
   logic [15:0] ml;

   always #4 clk = ~clk;

   lru_ins_stack #(.WAYS(WAYS), .LFSR_SEED(SEED)) u_lru_ins_stack (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
      .hit_way(hit_way), .fill_req(fill_req), .ins_mode(ins_mode),
      .victim_way(victim_way), .recency_flat(recency_flat));

   task automatic m_lift(int w);
      int p = 0;
      for (int i = 0; i < WAYS; i++) if (mo[i] == w) p = i;
      for (int i = p; i > 0; i--) mo[i] = mo[i-1];
      mo[0] = w;
   endtask

   task automatic check_state(string tag);
      logic [WAYS*IW-1:0] exp;
      for (int i = 0; i < WAYS; i++) exp[i*IW +: IW] = IW'(mo[i]);
      checks++;
      if (recency_flat !== exp) begin
         failures++;
         $display("FAIL %s order actual=%h expected=%h", tag, recency_flat, exp);
      end
      checks++;
      if (victim_way !== IW'(mo[WAYS-1])) begin
         failures++;
         $display("FAIL R2 (%s) victim actual=%0d expected=%0d", tag, victim_way, mo[WAYS-1]);
      end
   endtask

   task automatic op(bit v, bit h, int w, bit f, logic [1:0] md, string tag);
      @(negedge clk);
      acc_valid = v; acc_hit = h; hit_way = IW'(w); fill_req = f; ins_mode = md;
      if (v && h) m_lift(w);
      else if (f) begin
         if (md == 2'b10) begin
            bit d = (ml[4:0] == 5'd0);
            ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
            if (d) begin m_lift(mo[WAYS-1]); top_draws++; end
         end else if (md != 2'b01) m_lift(mo[WAYS-1]);
      end
      @(posedge clk); #1;
      acc_valid = 0; acc_hit = 0; fill_req = 0;
      check_state(tag);
   endtask

   task automatic t_reset();
      rst_n = 0;
      for (int i = 0; i < WAYS; i++) mo[i] = i;
      ml = SEED;
      repeat (3) @(posedge clk);
      #1; check_state("R1");
      @(negedge clk) rst_n = 1;
      @(negedge clk) check_state("R1");
   endtask

   task automatic t_hits();
      op(1, 1, 5, 0, 2'b00, "R3");
      op(1, 1, 7, 0, 2'b01, "R3");
      op(1, 1, 2, 0, 2'b10, "R3");
      op(1, 1, 2, 0, 2'b00, "R4");
   endtask

   task automatic t_top_fill();
      op(0, 0, 0, 1, 2'b00, "R5");
      op(0, 0, 0, 1, 2'b00, "R5");
      op(0, 0, 0, 1, 2'b11, "R5");
   endtask

   task automatic t_bottom_fill();
      int v;
      for (int k = 0; k < 4; k++) op(0, 0, 0, 1, 2'b01, "R6");
      v = mo[WAYS-1];
      op(1, 1, v, 0, 2'b01, "R6");
      checks++;
      if (recency_flat[IW-1:0] !== IW'(v)) begin
         failures++;
         $display("FAIL R6 lifted way actual=%0d expected=%0d", recency_flat[IW-1:0], v);
      end
   endtask

   task automatic t_bimodal();
      op(0, 0, 0, 1, 2'b10, "R7");
      checks++;
      if (top_draws != 1) begin
         failures++;
         $display("FAIL R7 first draw top actual=%0d expected=1", top_draws);
      end
      for (int k = 0; k < 150; k++) op(0, 0, 0, 1, 2'b10, "R10");
      checks++;
      if (top_draws < 2) begin
         failures++;
         $display("FAIL R10 top draws actual=%0d expected>=2", top_draws);
      end
   endtask

   task automatic t_priority_idle();
      op(1, 1, mo[4], 1, 2'b00, "R8");
      op(1, 1, mo[6], 1, 2'b10, "R8");
      op(0, 0, 0, 1, 2'b10, "R8");
      op(1, 0, 3, 0, 2'b00, "R9");
      op(0, 1, 3, 0, 2'b00, "R9");
      op(0, 0, 0, 0, 2'b10, "R9");
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      t_reset();
      t_hits();
      t_top_fill();
      t_bottom_fill();
      t_bimodal();
      t_priority_idle();
      done = 1;
      finish_run();
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end
endmodule